// File: doc/BRIEF.md
# Half-Duplex Line Direction Controller

This block drives the direction pin of a half-duplex line driver on behalf of a UART transmitter. It watches writes into the transmit FIFO, the FIFO-empty flag and the shifter-empty flag, and a 16x baud tick. A FIFO write turns the line to transmit at once. The line goes back to receive one full bit time after the final stop bit has left the shifter, provided nothing new was queued in the meantime.

The block also produces the transmit-interrupt request. In legacy mode the request follows the holding/FIFO-empty flag even while the shifter is still sending. In automatic mode the request is held back until the shifter has drained as well. Clearing the enable returns the pin to its idle level and restores legacy interrupt timing. A polarity input selects whether transmit is signalled by a low or a high pin level.

Top module: `txdir_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `dir_out` is at the idle level (high when `pol_inv`=0) and `tx_irq` is 0.
- R2: With `auto_en`=0, `tx_irq` equals `fifo_empty` as sampled at the previous clock edge, whatever the value of `shift_empty`.
- R3: With `auto_en`=1, `tx_irq` is 1 in a cycle only if both `fifo_empty` and `shift_empty` were 1 at the previous clock edge. Otherwise it is 0.
- R4: With `auto_en`=1, a `fifo_wr` sampled at a clock edge puts `dir_out` at the transmit level from that edge on.
- R5: Once `fifo_empty` and `shift_empty` are both 1 during transmit, `dir_out` keeps the transmit level through 15 ticks. Ticks are `tick16` pulses sampled at later edges. `dir_out` returns to idle at the edge that samples the 16th tick.
- R6: A `fifo_wr` during the R5 wait cancels the pending turnaround. The next drain restarts the count at zero, so a full 16 ticks are again needed.
- R7: The transmit level is 0 and the idle level is 1 when `pol_inv`=0. Both are inverted when `pol_inv`=1. The change takes effect without waiting for a clock edge.
- R8: When `auto_en` is 0, `dir_out` is at the idle level in the same cycle, and FIFO writes do not move it. After re-enabling, the pin stays idle until the next write.
- R9: If `shift_empty` or `fifo_empty` drops during the R5 wait, the wait is abandoned and the line stays in transmit. A later drain restarts the count at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_en | input | 1 | Automatic direction control enable |
| pol_inv | input | 1 | Inverts the direction pin polarity |
| fifo_wr | input | 1 | Write strobe into the transmit FIFO |
| fifo_empty | input | 1 | Transmit FIFO empty flag |
| shift_empty | input | 1 | Transmit shifter empty flag |
| tick16 | input | 1 | One-cycle pulse at 16x the baud rate |
| dir_out | output | 1 | Line driver direction pin |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
A wrong state register shows up at `dir_out` in the cycle after the edge that mis-stepped. One example is a turnaround that fires early or does not fire. Another is a write that fails to reclaim the line. A bad bit counter moves the turnaround by whole ticks, so it is found by counting ticks to the exact edge, with several tick spacings. Wrong interrupt gating is visible one cycle after the FIFO drains while the shifter is still busy.

// File: rtl/txdir_pkg.sv
package txdir_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XMIT = 2'd1,
    ST_HOLD = 2'd2
  } dir_state_e;

  // Pin level: transmit is low by default, inverted by inv.
  function automatic logic drv_level(logic xmit, logic inv);
    return xmit ? inv : ~inv;
  endfunction

  // Interrupt condition for legacy and automatic modes.
  function automatic logic irq_cond(logic auto_on, logic fe, logic se);
    return auto_on ? (fe & se) : fe;
  endfunction

endpackage

// File: rtl/txdir_bitcnt.sv
module txdir_bitcnt #(
  parameter int BIT_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int CNT_W = (BIT_TICKS > 1) ? $clog2(BIT_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done = run & tick & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!run)      cnt_q <= '0;
    else if (done)      cnt_q <= '0;
    else if (tick)      cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/txdir_fsm.sv
module txdir_fsm
  import txdir_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       auto_en,
  input  logic       fifo_wr,
  input  logic       fifo_empty,
  input  logic       shift_empty,
  input  logic       bit_done,
  output dir_state_e state_o,
  output logic       hold_run
);
  dir_state_e state_q, state_d;
  logic drained;

  assign drained  = fifo_empty & shift_empty;
  assign hold_run = auto_en & (state_q == ST_HOLD) & drained & ~fifo_wr;
  assign state_o  = state_q;

  always_comb begin
    state_d = state_q;
    if (!auto_en)     state_d = ST_IDLE;
    else if (fifo_wr) state_d = ST_XMIT;
    else begin
      case (state_q)
        ST_XMIT: if (drained) state_d = ST_HOLD;
        ST_HOLD: begin
          if (!drained)      state_d = ST_XMIT;
          else if (bit_done) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  AST_OFF_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> state_q == ST_IDLE); // R8
  AST_WR_TO_XMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && fifo_wr) |=> state_q == ST_XMIT); // R4
  AST_TURN_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && $past(state_q) == ST_HOLD && $past(auto_en)) |-> $past(bit_done)); // R5
  AST_BUSY_STAYS_XMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && state_q == ST_HOLD && !drained) |=> state_q == ST_XMIT); // R9

endmodule

// File: rtl/txdir_irq.sv
module txdir_irq
  import txdir_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic fifo_empty,
  input  logic shift_empty,
  output logic tx_irq
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_cond(auto_en, fifo_empty, shift_empty);
  end

  assign tx_irq = irq_q;

  AST_IRQ_WAITS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !shift_empty) |=> !tx_irq); // R3
  AST_IRQ_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en && fifo_empty) |=> tx_irq); // R2

endmodule

// File: rtl/txdir_ctrl.sv
module txdir_ctrl
  import txdir_pkg::*;
#(
  parameter int BIT_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic pol_inv,
  input  logic fifo_wr,
  input  logic fifo_empty,
  input  logic shift_empty,
  input  logic tick16,
  output logic dir_out,
  output logic tx_irq
);
  dir_state_e state_w;
  logic       hold_run_w;
  logic       bit_done_w;
  logic       xmit_w;

  txdir_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .auto_en     (auto_en),
    .fifo_wr     (fifo_wr),
    .fifo_empty  (fifo_empty),
    .shift_empty (shift_empty),
    .bit_done    (bit_done_w),
    .state_o     (state_w),
    .hold_run    (hold_run_w)
  );

  txdir_bitcnt #(.BIT_TICKS(BIT_TICKS)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (hold_run_w),
    .tick  (tick16),
    .done  (bit_done_w)
  );

  txdir_irq u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .auto_en     (auto_en),
    .fifo_empty  (fifo_empty),
    .shift_empty (shift_empty),
    .tx_irq      (tx_irq)
  );

  assign xmit_w  = auto_en & (state_w != ST_IDLE);
  assign dir_out = drv_level(xmit_w, pol_inv);

  AST_WR_DRIVES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && fifo_wr && $stable(pol_inv)) |=> (!auto_en || dir_out == pol_inv)); // R4
  AST_HOLD_KEEPS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && state_w == ST_HOLD) |-> dir_out == pol_inv); // R5

endmodule

// File: tb/txdir_ctrl_tb.sv
`timescale 1ns/1ps
module txdir_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic auto_en = 1'b0, pol_inv = 1'b0, fifo_wr = 1'b0;
  logic fifo_empty = 1'b1, shift_empty = 1'b1, tick16 = 1'b0;
  wire  dir_out, tx_irq;
  int   vecs = 0, miss = 0;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  txdir_ctrl #(.BIT_TICKS(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .pol_inv(pol_inv),
    .fifo_wr(fifo_wr), .fifo_empty(fifo_empty), .shift_empty(shift_empty),
    .tick16(tick16), .dir_out(dir_out), .tx_irq(tx_irq)
  );

  // Expected pin: transmit equals pol_inv, idle is its complement (R7).
  function automatic logic exp_pin(logic xmit, logic inv);
    return inv ^ !xmit;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      tick16 = 1'b1; cyc();
      tick16 = 1'b0; cyc(gap - 1);
    end
  endtask

  task automatic start_char();
    fifo_wr = 1'b1; fifo_empty = 1'b0; shift_empty = 1'b0;
    cyc();
    fifo_wr = 1'b0;
    cyc(2);
  endtask

  task automatic drain();
    fifo_empty = 1'b1; shift_empty = 1'b1;
    cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miss++; vecs++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk("R1 dir in reset", dir_out, 1'b1);
    chk("R1 irq in reset", tx_irq, 1'b0);
    rst_n = 1'b1;
    #1;
    chk("R1 irq after release", tx_irq, 1'b0);
    chk("R1 dir after release", dir_out, 1'b1);
    cyc();

    for (int inv = 0; inv < 2; inv++) begin
      for (int gap = 1; gap <= 3; gap++) begin
        pol_inv = inv[0]; auto_en = 1'b1;
        #1 chk("R7 idle level", dir_out, exp_pin(1'b0, pol_inv));

        // R4/R3/R5: basic transmit, drain, turnaround
        start_char();
        chk("R4 write claims line", dir_out, exp_pin(1'b1, pol_inv));
        chk("R7 transmit level", dir_out, exp_pin(1'b1, pol_inv));
        chk("R3 irq while fifo busy", tx_irq, 1'b0);
        fifo_empty = 1'b1; cyc();
        chk("R3 irq while shifter busy", tx_irq, 1'b0);
        shift_empty = 1'b1; cyc();
        chk("R3 irq after full drain", tx_irq, 1'b1);
        ticks(15, gap);
        chk("R5 held through 15 ticks", dir_out, exp_pin(1'b1, pol_inv));
        ticks(1, gap);
        chk("R5 idle after 16th tick", dir_out, exp_pin(1'b0, pol_inv));

        // R6: write at every point of the wait
        for (int k = 0; k < 16; k++) begin
          start_char(); drain();
          ticks(k, gap);
          fifo_wr = 1'b1; fifo_empty = 1'b0; cyc();
          fifo_wr = 1'b0;
          chk("R6 write cancels wait", dir_out, exp_pin(1'b1, pol_inv));
          drain();
          ticks(15, gap);
          chk("R6 count restarted", dir_out, exp_pin(1'b1, pol_inv));
          ticks(1, gap);
          chk("R6 idle after fresh 16", dir_out, exp_pin(1'b0, pol_inv));
        end

        // R9: shifter restarts during the wait
        start_char(); drain();
        ticks(5, gap);
        shift_empty = 1'b0; cyc();
        chk("R9 busy shifter keeps line", dir_out, exp_pin(1'b1, pol_inv));
        shift_empty = 1'b1; cyc();
        ticks(15, gap);
        chk("R9 count restarted", dir_out, exp_pin(1'b1, pol_inv));
        ticks(1, gap);
        chk("R9 idle after fresh 16", dir_out, exp_pin(1'b0, pol_inv));

        // R8: disable mid-transmit
        start_char();
        auto_en = 1'b0;
        #1 chk("R8 disable is immediate", dir_out, exp_pin(1'b0, pol_inv));
        cyc();
        auto_en = 1'b1;
        #1 chk("R8 stays idle on re-enable", dir_out, exp_pin(1'b0, pol_inv));
        drain(); cyc();
      end
    end

    // R2 / R8: legacy mode
    pol_inv = 1'b0; auto_en = 1'b0;
    start_char();
    chk("R8 write ignored when off", dir_out, 1'b1);
    fifo_empty = 1'b1; shift_empty = 1'b0; cyc();
    chk("R2 irq with shifter busy", tx_irq, 1'b1);
    fifo_empty = 1'b0; cyc();
    chk("R2 irq drops with data", tx_irq, 1'b0);
    drain();
    chk("R2 irq on empty", tx_irq, 1'b1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule